// File: doc/BRIEF.md
# Bidding Interrupt Arbiter with Capture

This block decides which of the ten interrupt conditions of a single-channel serial controller should be serviced next. Every condition places a numeric bid. The bid's upper byte is an urgency level, and a source code and the channel number sit below it. The two receive conditions take their level from the live receive FIFO fill count. The transmit condition takes it from the live transmit FIFO empty count. The seven conditions that have no FIFO take a byte that software writes. The largest bid is compared against a programmable threshold to raise the interrupt request.

When the host acknowledges the interrupt, or writes an update command, the bid that leads the auction at that moment is latched into a current-interrupt register. This may be a different source from the one that first raised the request. From the same capture the block forms a vector: a base vector with its low three bits replaced by the low bits of the winning source code. A captured value of zero means that nothing was pending.

Top module: `bid_irq_arbiter`

## Requirements
- R1: A bid is {level[7:0], code[3:0], channel[CHAN_W-1:0]} (level in the MSBs, channel in the LSBs) and bids are compared as unsigned numbers. Source index i (0..9) carries code i+1, in this order: receive ok, receive error, receive timeout, transmit, break change, loopback error, pin change, flow character, counter/timer, address match.
- R2: Sources 0 and 1 (receive ok, receive error) use `rx_fill` as their level; source 3 (transmit) uses `tx_empty`.
- R3: Every other source i uses byte i of `sw_weight` (bits 8i+7..8i); bytes 0, 1 and 3 of `sw_weight` have no effect.
- R4: A source bids only when both its `src_en` bit and its `src_pend` bit are 1; otherwise its bid is zero.
- R5: `irq` is registered: one clock after an edge where the largest bid is strictly greater than `thresh` it is 1, otherwise 0 (equality gives 0).
- R6: A 1 on `iack` at a clock edge loads the largest bid present at that edge into `cir`; without a strobe `cir` holds its value even when the bids change.
- R7: A 1 on `upd_cmd` captures exactly as `iack` does.
- R8: If no source is active at capture time, `cir` becomes 0 and `vec[2:0]` becomes 0.
- R9: At the same edge as the capture, `vec` becomes {base_vec[7:3], winning code[2:0]}.
- R10: Between two bids of equal level, the source with the higher code wins.
- R11: Synchronous reset clears `irq`, `cir` and `vec` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_pend | input | 10 | Pending condition per source |
| src_en | input | 10 | Software enable per source |
| rx_fill | input | LVL_W | Receive FIFO fill count |
| tx_empty | input | LVL_W | Transmit FIFO empty count |
| sw_weight | input | 10*LVL_W | Software level byte per source |
| thresh | input | BID_W | Request threshold |
| base_vec | input | VEC_W | Base interrupt vector |
| iack | input | 1 | Interrupt acknowledge strobe |
| upd_cmd | input | 1 | Host update command strobe |
| irq | output | 1 | Interrupt request |
| cir | output | BID_W | Captured winning bid |
| vec | output | VEC_W | Modified vector from the capture |

## Verification
On every cycle the assertions check four things: the request follows the previous cycle's comparison of the auction winner with the threshold; a strobe loads the winner, and without one the captured bid stays put; the vector's low bits always agree with the code field of the captured bid; and the winner is zero when no source is both enabled and pending. Some behaviour only the directed scenarios can show. That covers the selection of each source's level (which FIFO count or software byte is used), the tie order between codes, and the case where a source overtakes after the request rose and before the acknowledge. It also covers the exact packed values of the captured bid and the vector for chosen inputs.

// File: rtl/iarb_pkg.sv
`timescale 1ns/1ps
package iarb_pkg;
  localparam int NUM_SRC = 10;
  localparam int CODE_W  = 4;
  localparam int VSEL_W  = 3;
  // Source indices; the code of source i is i+1
  localparam int SRC_RX_OK  = 0;
  localparam int SRC_RX_ERR = 1;
  localparam int SRC_RX_TMO = 2;
  localparam int SRC_TX     = 3;
  localparam int SRC_BRK    = 4;
  localparam int SRC_LPBK   = 5;
  localparam int SRC_PIN    = 6;
  localparam int SRC_FLOW   = 7;
  localparam int SRC_CTR    = 8;
  localparam int SRC_ADDR   = 9;

  typedef enum logic [1:0] {LVL_RX, LVL_TX, LVL_SW} lvl_sel_e;

  function automatic lvl_sel_e lvl_sel(input int idx);
    if (idx == SRC_RX_OK || idx == SRC_RX_ERR) return LVL_RX;
    if (idx == SRC_TX) return LVL_TX;
    return LVL_SW;
  endfunction
endpackage

// File: rtl/iarb_bid_form.sv
`timescale 1ns/1ps
module iarb_bid_form
  import iarb_pkg::*;
#(
  parameter int LVL_W   = 8,
  parameter int CHAN_W  = 2,
  parameter int CHAN_ID = 0,
  localparam int BID_W  = LVL_W + CODE_W + CHAN_W
) (
  input  logic [NUM_SRC-1:0]       act,
  input  logic [LVL_W-1:0]         rx_fill,
  input  logic [LVL_W-1:0]         tx_empty,
  input  logic [NUM_SRC*LVL_W-1:0] sw_weight,
  output logic [NUM_SRC*BID_W-1:0] bids
);
  localparam logic [CHAN_W-1:0] CHAN = CHAN_W'(CHAN_ID);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam logic [CODE_W-1:0] CODE = CODE_W'(i + 1);
    logic [LVL_W-1:0] lvl;
    if (lvl_sel(i) == LVL_RX) begin : g_rx
      logic unused_sw;
      assign unused_sw = ^sw_weight[i*LVL_W +: LVL_W];
      assign lvl = rx_fill;
    end else if (lvl_sel(i) == LVL_TX) begin : g_tx
      logic unused_sw;
      assign unused_sw = ^sw_weight[i*LVL_W +: LVL_W];
      assign lvl = tx_empty;
    end else begin : g_sw
      assign lvl = sw_weight[i*LVL_W +: LVL_W];
    end
    assign bids[i*BID_W +: BID_W] = act[i] ? {lvl, CODE, CHAN} : '0;
  end
endmodule

// File: rtl/iarb_max.sv
`timescale 1ns/1ps
module iarb_max #(
  parameter int N = 10,
  parameter int W = 14
) (
  input  logic [N*W-1:0] vals,
  output logic [W-1:0]   best
);
  always_comb begin
    best = '0;
    for (int i = 0; i < N; i++) begin
      if (vals[i*W +: W] > best) best = vals[i*W +: W];
    end
  end
endmodule

// File: rtl/iarb_capture.sv
`timescale 1ns/1ps
module iarb_capture
  import iarb_pkg::*;
#(
  parameter int BID_W  = 14,
  parameter int CHAN_W = 2,
  parameter int VEC_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BID_W-1:0] best,
  input  logic [BID_W-1:0] thresh,
  input  logic [VEC_W-1:0] base_vec,
  input  logic             take,
  output logic             irq,
  output logic [BID_W-1:0] cir,
  output logic [VEC_W-1:0] vec
);
  logic unused_base;
  assign unused_base = ^base_vec[VSEL_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      irq <= 1'b0;
      cir <= '0;
      vec <= '0;
    end else begin
      irq <= (best > thresh);
      if (take) begin
        cir <= best;
        vec <= {base_vec[VEC_W-1:VSEL_W], best[CHAN_W +: VSEL_W]};
      end
    end
  end
endmodule

// File: rtl/bid_irq_arbiter.sv
`timescale 1ns/1ps
module bid_irq_arbiter
  import iarb_pkg::*;
#(
  parameter int LVL_W   = 8,
  parameter int CHAN_W  = 2,
  parameter int CHAN_ID = 0,
  parameter int VEC_W   = 8
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [NUM_SRC-1:0]                src_pend,
  input  logic [NUM_SRC-1:0]                src_en,
  input  logic [LVL_W-1:0]                  rx_fill,
  input  logic [LVL_W-1:0]                  tx_empty,
  input  logic [NUM_SRC*LVL_W-1:0]          sw_weight,
  input  logic [LVL_W+CODE_W+CHAN_W-1:0]    thresh,
  input  logic [VEC_W-1:0]                  base_vec,
  input  logic                              iack,
  input  logic                              upd_cmd,
  output logic                              irq,
  output logic [LVL_W+CODE_W+CHAN_W-1:0]    cir,
  output logic [VEC_W-1:0]                  vec
);
  localparam int BID_W = LVL_W + CODE_W + CHAN_W;

  logic [NUM_SRC-1:0]       act;
  logic [NUM_SRC*BID_W-1:0] bids;
  logic [BID_W-1:0]         best;

  assign act = src_en & src_pend;

  iarb_bid_form #(.LVL_W(LVL_W), .CHAN_W(CHAN_W), .CHAN_ID(CHAN_ID)) u_form (
    .act(act), .rx_fill(rx_fill), .tx_empty(tx_empty),
    .sw_weight(sw_weight), .bids(bids)
  );

  iarb_max #(.N(NUM_SRC), .W(BID_W)) u_max (
    .vals(bids), .best(best)
  );

  iarb_capture #(.BID_W(BID_W), .CHAN_W(CHAN_W), .VEC_W(VEC_W)) u_cap (
    .clk(clk), .rst(rst), .best(best), .thresh(thresh),
    .base_vec(base_vec), .take(iack | upd_cmd),
    .irq(irq), .cir(cir), .vec(vec)
  );
endmodule

// File: rtl/bid_irq_arbiter_chk.sv
`timescale 1ns/1ps
module bid_irq_arbiter_chk
  import iarb_pkg::*;
#(
  parameter int BID_W  = 14,
  parameter int CHAN_W = 2,
  parameter int VEC_W  = 8
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] src_en,
  input logic [NUM_SRC-1:0] src_pend,
  input logic [BID_W-1:0]   thresh,
  input logic               iack,
  input logic               upd_cmd,
  input logic [BID_W-1:0]   best,
  input logic               irq,
  input logic [BID_W-1:0]   cir,
  input logic [VEC_W-1:0]   vec
);
  assert_reset_clear_R11: assert property (@(posedge clk)
    rst |=> (!irq && cir == '0 && vec == '0));

  assert_irq_follows_R5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(best > thresh)));

  assert_capture_R6: assert property (@(posedge clk) disable iff (rst)
    (iack || upd_cmd) |=> (cir == $past(best)));

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !(iack || upd_cmd) |=> $stable(cir) && $stable(vec));

  assert_vec_code_R9: assert property (@(posedge clk) disable iff (rst)
    vec[VSEL_W-1:0] == cir[CHAN_W +: VSEL_W]);

  assert_idle_zero_R4: assert property (@(posedge clk) disable iff (rst)
    ((src_en & src_pend) == '0) |-> (best == '0));
endmodule

bind bid_irq_arbiter bid_irq_arbiter_chk #(
  .BID_W(LVL_W + iarb_pkg::CODE_W + CHAN_W), .CHAN_W(CHAN_W), .VEC_W(VEC_W)
) u_chk (
  .clk(clk), .rst(rst), .src_en(src_en), .src_pend(src_pend),
  .thresh(thresh), .iack(iack), .upd_cmd(upd_cmd), .best(best),
  .irq(irq), .cir(cir), .vec(vec)
);

// File: tb/bid_irq_arbiter_test.sv
`timescale 1ns/1ps
module bid_irq_arbiter_test;
  localparam int NS = 10;
  localparam int LW = 8;
  localparam int CW = 2;
  localparam int CH = 1;
  localparam int BW = LW + 4 + CW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NS-1:0]    src_pend = '0;
  logic [NS-1:0]    src_en = '0;
  logic [LW-1:0]    rx_fill = '0;
  logic [LW-1:0]    tx_empty = '0;
  logic [NS*LW-1:0] sw_weight = '0;
  logic [BW-1:0]    thresh = '0;
  logic [7:0]       base_vec = 8'hA8;
  logic             iack = 1'b0;
  logic             upd_cmd = 1'b0;
  logic             irq;
  logic [BW-1:0]    cir;
  logic [7:0]       vec;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bid_irq_arbiter #(.LVL_W(LW), .CHAN_W(CW), .CHAN_ID(CH), .VEC_W(8)) uut (
    .clk(clk), .rst(rst), .src_pend(src_pend), .src_en(src_en),
    .rx_fill(rx_fill), .tx_empty(tx_empty), .sw_weight(sw_weight),
    .thresh(thresh), .base_vec(base_vec), .iack(iack), .upd_cmd(upd_cmd),
    .irq(irq), .cir(cir), .vec(vec)
  );

  // Expected winner from the requirements R1-style packing
  function automatic logic [BW-1:0] mk(input int idx, input logic [LW-1:0] l);
    return {l, 4'(idx + 1), 2'(CH)};
  endfunction

  function automatic logic [BW-1:0] model();
    logic [BW-1:0] b = '0;
    for (int i = 0; i < NS; i++) begin
      logic [LW-1:0] l;
      if (i == 0 || i == 1) l = rx_fill;
      else if (i == 3) l = tx_empty;
      else l = sw_weight[i*LW +: LW];
      if (src_en[i] && src_pend[i] && mk(i, l) > b) b = mk(i, l);
    end
    return b;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic capture(input bit use_cmd);
    if (use_cmd) upd_cmd = 1'b1; else iack = 1'b1;
    step();
    iack = 1'b0;
    upd_cmd = 1'b0;
  endtask

  task automatic clear_src();
    src_en = '0; src_pend = '0; rx_fill = '0; tx_empty = '0; sw_weight = '0;
    thresh = '0;
  endtask

  task automatic t_reset();
    chk("R11 irq after reset", 32'(irq), 0);
    chk("R11 cir after reset", 32'(cir), 0);
    chk("R11 vec after reset", 32'(vec), 0);
  endtask

  task automatic t_rx_level();
    clear_src();
    src_en[0] = 1; src_pend[0] = 1; rx_fill = 8'h25; sw_weight[7:0] = 8'hFF;
    capture(1'b0);
    chk("R1 R2 rx ok bid", 32'(cir), 32'h945);
    src_en[1] = 1; src_pend[1] = 1;
    capture(1'b1);
    chk("R2 rx err uses rx fill", 32'(cir), 32'(mk(1, 8'h25)));
  endtask

  task automatic t_tx_level();
    clear_src();
    src_en[3] = 1; src_pend[3] = 1; tx_empty = 8'h40; sw_weight[3*LW +: LW] = 8'hF0;
    capture(1'b0);
    chk("R2 tx uses empty count", 32'(cir), 32'(mk(3, 8'h40)));
  endtask

  task automatic t_sw_level();
    clear_src();
    src_en[8] = 1; src_pend[8] = 1; sw_weight[8*LW +: LW] = 8'h33; rx_fill = 8'hEE;
    capture(1'b0);
    chk("R3 counter source uses sw byte", 32'(cir), 32'(mk(8, 8'h33)));
    src_en[2] = 1; src_pend[2] = 1; sw_weight[2*LW +: LW] = 8'h50;
    capture(1'b0);
    chk("R3 timeout sw byte wins", 32'(cir), 32'(mk(2, 8'h50)));
    // bytes 0,1,3 ignored: fifo sources idle, their bytes large
    sw_weight[7:0] = 8'hFF; sw_weight[15:8] = 8'hFF; sw_weight[31:24] = 8'hFF;
    capture(1'b1);
    chk("R3 fifo source bytes no effect", 32'(cir), 32'(mk(2, 8'h50)));
  endtask

  task automatic t_enable_mask();
    clear_src();
    src_pend = '1; src_en = 10'b0000010000; sw_weight = '1; rx_fill = 8'hFF; tx_empty = 8'hFF;
    capture(1'b0);
    chk("R4 only enabled source bids", 32'(cir), 32'(mk(4, 8'hFF)));
    src_en = '1; src_pend = 10'b0000000100;
    capture(1'b0);
    chk("R4 only pending source bids", 32'(cir), 32'(mk(2, 8'hFF)));
  endtask

  task automatic t_threshold();
    clear_src();
    src_en[5] = 1; src_pend[5] = 1; sw_weight[5*LW +: LW] = 8'h10;
    thresh = mk(5, 8'h10);
    step();
    chk("R5 equal threshold no irq", 32'(irq), 0);
    thresh = mk(5, 8'h10) - 1;
    step();
    chk("R5 above threshold irq", 32'(irq), 1);
    src_pend[5] = 0;
    step();
    chk("R5 irq drops when idle", 32'(irq), 0);
  endtask

  task automatic t_overtake();
    clear_src();
    src_en = '1; src_pend[0] = 1; rx_fill = 8'h20; thresh = mk(0, 8'h10);
    step();
    chk("R5 rx raised irq", 32'(irq), 1);
    src_pend[3] = 1; tx_empty = 8'h80;
    capture(1'b0);
    chk("R6 ack captures current winner", 32'(cir), 32'(mk(3, 8'h80)));
    tx_empty = 8'h90; rx_fill = 8'hF0;
    step(); step();
    chk("R6 cir holds without strobe", 32'(cir), 32'(mk(3, 8'h80)));
    capture(1'b1);
    chk("R7 update command captures", 32'(cir), 32'(model()));
  endtask

  task automatic t_tie();
    clear_src();
    src_en = '1; src_pend = 10'b1000100000;
    sw_weight[5*LW +: LW] = 8'h44; sw_weight[9*LW +: LW] = 8'h44;
    capture(1'b0);
    chk("R10 higher code wins tie", 32'(cir), 32'(mk(9, 8'h44)));
    sw_weight[5*LW +: LW] = 8'h45;
    capture(1'b0);
    chk("R10 higher level beats higher code", 32'(cir), 32'(mk(5, 8'h45)));
  endtask

  task automatic t_vector();
    clear_src();
    base_vec = 8'hA8;
    src_en[6] = 1; src_pend[6] = 1; sw_weight[6*LW +: LW] = 8'h01;
    capture(1'b0);
    chk("R9 vector code 7", 32'(vec), 32'hAF);
    base_vec = 8'h50;
    step();
    chk("R9 vector holds until capture", 32'(vec), 32'hAF);
    src_en[9] = 1; src_pend[9] = 1; sw_weight[9*LW +: LW] = 8'h02;
    capture(1'b1);
    chk("R9 vector code 10 low bits", 32'(vec), 32'h52);
  endtask

  task automatic t_idle();
    clear_src();
    src_en = '1;
    capture(1'b0);
    chk("R8 idle cir zero", 32'(cir), 0);
    chk("R8 idle vec low bits zero", 32'(vec[2:0]), 0);
    chk("R8 idle no irq", 32'(irq), 0);
  endtask

  initial begin
    repeat (3) step();
    rst = 1'b0;
    step();
    t_reset();
    t_rx_level();
    t_tx_level();
    t_sw_level();
    t_enable_mask();
    t_threshold();
    t_overtake();
    t_tie();
    t_vector();
    t_idle();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule